// File: doc/BRIEF.md
# Configurable-Frame UART Transmitter

This block turns one parallel character into an asynchronous serial frame on a single line that rests high. A frame is a low start bit, then 5 to 8 data bits sent least significant first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. The frame shape is chosen per character through width, parity and stop inputs. These inputs are captured when the character is taken, so they may change while a frame is on the line.

Bit timing comes from a clock-enable pulse at sixteen times the baud rate. Every bit lasts sixteen of these pulses. The stop period is counted in half-bit steps of eight pulses, which gives the one-and-a-half option exactly. A character is offered with a valid/ready handshake. Ready stays low from the moment a character is taken until its stop period has ended, and a busy flag marks the same span.

Top module: `uart_frame_tx`

## Requirements
- R1: When txValid and txReady are both high at a clock edge, the character is taken at that edge. From that edge txLine is low (start bit) and busy is high. The start bit lasts 16 ticks.
- R2: Out of reset and whenever no frame is in progress, txLine is high, txReady is high and busy is low.
- R3: The data bits follow the start bit, each lasting 16 ticks, least significant bit first. widthSel selects the count of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R4: Bits of txData above the selected width have no effect on the line or on the parity.
- R5: With parityOn high, one parity bit of 16 ticks follows the last data bit. The parity is computed over the data bits in use only. parityOdd low gives even parity (the XOR of the data bits). parityOdd high gives odd parity (its inverse).
- R6: With parityOn low, no parity bit is sent, and the stop period follows the last data bit directly.
- R7: The stop period is high. stopSel selects its length: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks.
- R8: Changes to txData, widthSel, parityOn, parityOdd and stopSel after the character is taken do not alter the frame in progress.
- R9: txReady is low and busy is high from the taking edge until the tick that ends the stop period, at which both return to idle. A txValid held high meanwhile is ignored, and a new character can be taken on the next clock.
- R10: Apart from the taking edge, txLine changes only on clock edges where tickEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse at 16x the baud rate |
| txData | input | 8 | Character to send |
| txValid | input | 1 | Character offered |
| txReady | output | 1 | Block can take a character |
| widthSel | input | 2 | Data bit count select (5 to 8) |
| parityOn | input | 1 | Send a parity bit |
| parityOdd | input | 1 | Odd parity when high, even when low |
| stopSel | input | 2 | Stop length select (1, 1.5, 2 bits) |
| txLine | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: sixteen ticks per bit and an eight-bit character. With these values the half-bit stop step is eight ticks, and every width, parity and stop combination is reachable within a few hundred ticks per frame. The tick pulse arrives with random gaps, so the line is checked for staying still between ticks and for changing on the correct tick. The frame inputs are scrambled while each frame is running, and some frames are sent back to back with txValid held high. This exercises config capture at the taking edge and the hand-off at the end of the stop period.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
  // Strobes from sequencer to datapath, at most one high per cycle
  typedef struct packed {
    logic load;        // capture character, drive start bit
    logic nextData;    // drive next data bit
    logic sendParity;  // drive parity bit
    logic sendStop;    // drive stop level
  } txStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } txState_t;
endpackage

// File: rtl/uftx_ctrl.sv
module uftx_ctrl
  import uftx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       txValid,
  input  logic [1:0] widthSel,
  input  logic       parityOn,
  input  logic [1:0] stopSel,
  output logic       txReady,
  output logic       busy,
  output txStrobe_t  strobe
);
  localparam int TW   = $clog2(OVERSAMPLE);
  localparam int HALF = OVERSAMPLE / 2;
  localparam int BW   = $clog2(DATA_MAX);

  txState_t        state;
  logic [TW-1:0]   tickCnt;
  logic [BW-1:0]   bitCnt;
  logic [BW-1:0]   lastBit;
  logic            parOnQ;
  logic [1:0]      halfCnt;
  logic [1:0]      stopHalvesM1;

  logic bitDone, halfDone;
  assign bitDone  = tickEn && (tickCnt == TW'(OVERSAMPLE - 1));
  assign halfDone = tickEn && (tickCnt == TW'(HALF - 1));

  assign txReady = (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE:   strobe.load = txValid;
      ST_START:  strobe.nextData = bitDone;
      ST_DATA:
        if (bitDone) begin
          if (bitCnt != lastBit)  strobe.nextData   = 1'b1;
          else if (parOnQ)        strobe.sendParity = 1'b1;
          else                    strobe.sendStop   = 1'b1;
        end
      ST_PARITY: strobe.sendStop = bitDone;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      tickCnt      <= '0;
      bitCnt       <= '0;
      lastBit      <= '0;
      parOnQ       <= 1'b0;
      halfCnt      <= '0;
      stopHalvesM1 <= '0;
    end else begin
      if (tickEn) tickCnt <= tickCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (txValid) begin
            state        <= ST_START;
            lastBit      <= BW'(DATA_MAX - 4) + BW'(widthSel);
            parOnQ       <= parityOn;
            stopHalvesM1 <= (stopSel == 2'd0) ? 2'd1 :
                            (stopSel == 2'd1) ? 2'd2 : 2'd3;
          end
        end
        ST_START:
          if (bitDone) begin
            state   <= ST_DATA;
            bitCnt  <= '0;
            tickCnt <= '0;
          end
        ST_DATA:
          if (bitDone) begin
            tickCnt <= '0;
            halfCnt <= '0;
            if (bitCnt != lastBit) bitCnt <= bitCnt + 1'b1;
            else                   state  <= parOnQ ? ST_PARITY : ST_STOP;
          end
        ST_PARITY:
          if (bitDone) begin
            state   <= ST_STOP;
            tickCnt <= '0;
            halfCnt <= '0;
          end
        ST_STOP:
          if (halfDone) begin
            tickCnt <= '0;
            if (halfCnt == stopHalvesM1) state   <= ST_IDLE;
            else                         halfCnt <= halfCnt + 1'b1;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uftx_dpath.sv
module uftx_dpath
  import uftx_pkg::*;
#(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strobe,
  input  logic [DATA_MAX-1:0] txData,
  input  logic                parityOdd,
  output logic                txLine
);
  logic [DATA_MAX-1:0] shiftQ;
  logic                parAcc;
  logic                oddQ;
  logic                lineQ;

  assign txLine = lineQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      parAcc <= 1'b0;
      oddQ   <= 1'b0;
      lineQ  <= 1'b1;
    end else if (strobe.load) begin
      shiftQ <= txData;
      parAcc <= 1'b0;
      oddQ   <= parityOdd;
      lineQ  <= 1'b0;
    end else if (strobe.nextData) begin
      // Only bits in use are ever shifted out, so parity covers just those
      lineQ  <= shiftQ[0];
      parAcc <= parAcc ^ shiftQ[0];
      shiftQ <= shiftQ >> 1;
    end else if (strobe.sendParity) begin
      lineQ <= parAcc ^ oddQ;
    end else if (strobe.sendStop) begin
      lineQ <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic [DATA_MAX-1:0] txData,
  input  logic                txValid,
  output logic                txReady,
  input  logic [1:0]          widthSel,
  input  logic                parityOn,
  input  logic                parityOdd,
  input  logic [1:0]          stopSel,
  output logic                txLine,
  output logic                busy
);
  txStrobe_t strobe;

  uftx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_MAX(DATA_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .txValid(txValid),
    .widthSel(widthSel), .parityOn(parityOn), .stopSel(stopSel),
    .txReady(txReady), .busy(busy), .strobe(strobe)
  );

  uftx_dpath #(.DATA_MAX(DATA_MAX)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .parityOdd(parityOdd), .txLine(txLine)
  );
endmodule

// File: rtl/uftx_checker.sv
module uftx_checker (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic txValid,
  input logic txReady,
  input logic txLine,
  input logic busy
);
  a_r1_start_on_take: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (!txLine && busy && !txReady));

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  a_r9_ready_low_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !txReady);

  a_r9_end_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(tickEn));

  a_r10_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !(txValid && txReady)) |=> $stable(txLine));
endmodule

bind uart_frame_tx uftx_checker uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .txValid(txValid),
  .txReady(txReady), .txLine(txLine), .busy(busy)
);

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
module tb_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [1:0] widthSel = '0;
  logic       parityOn = 1'b0;
  logic       parityOdd = 1'b0;
  logic [1:0] stopSel = '0;
  logic       txLine;
  logic       busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_frame_tx dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .txData(txData),
    .txValid(txValid), .txReady(txReady), .widthSel(widthSel),
    .parityOn(parityOn), .parityOdd(parityOdd), .stopSel(stopSel),
    .txLine(txLine), .busy(busy)
  );

  // Tick pulse with random gaps, updated between edges
  initial begin
    void'($urandom(32'h5EED_0017));
    forever begin
      @(posedge clk); #1.5;
      tickEn = ($urandom % 3) == 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expBit(input int idx, input logic [7:0] d,
                                input logic [1:0] w, input bit pe, input bit po);
    int nData = 5 + w;
    logic [7:0] mask = 8'((1 << nData) - 1);
    if (idx == 0) return 1'b0;
    if (idx <= nData) return d[idx-1];
    if (pe && idx == nData + 1) return (^(d & mask)) ^ po;
    return 1'b1;
  endfunction

  function automatic int stopTicks(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
  endfunction

  task automatic sendFrame(input logic [7:0] d, input logic [1:0] w, input bit pe,
                           input bit po, input logic [1:0] s, input bit holdV);
    int total, k;
    bit t, prevLine;
    total = 16 * (1 + 5 + w + pe) + stopTicks(s);
    @(negedge clk);
    txData = d; widthSel = w; parityOn = pe; parityOdd = po; stopSel = s;
    txValid = 1'b1;
    check(txReady == 1'b1, "R9 ready before take", txReady, 1);
    @(posedge clk); #1;
    check(txLine == 1'b0 && busy && !txReady, "R1 start at take",
          {txLine, busy, txReady}, 3'b010);
    prevLine = txLine;
    k = 0;
    while (k < total) begin
      @(negedge clk);
      // R8: scramble frame inputs mid-frame; R9: txValid may stay high
      txData = 8'($urandom); widthSel = 2'($urandom); parityOn = 1'($urandom);
      parityOdd = 1'($urandom); stopSel = 2'($urandom); txValid = holdV;
      t = tickEn;
      @(posedge clk); #1;
      if (t) begin
        k++;
        if (k < total) begin
          check(txLine == expBit(k / 16, d, w, pe, po), "R3 R5 R6 R7 R8 frame bit",
                txLine, expBit(k / 16, d, w, pe, po));
          check(!txReady && busy, "R9 ready low in frame", {txReady, busy}, 2'b01);
        end else begin
          check(txLine == 1'b1 && txReady && !busy, "R7 R9 stop end",
                {txLine, txReady, busy}, 3'b110);
        end
      end else begin
        check(txLine == prevLine, "R10 line still between ticks", txLine, prevLine);
      end
      prevLine = txLine;
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(txLine && txReady && !busy, "R2 reset state", {txLine, txReady, busy}, 3'b110);
    repeat (7) @(posedge clk); #1;
    check(txLine && txReady && !busy, "R2 idle held", {txLine, txReady, busy}, 3'b110);

    // R3 each width, R5 both senses, R7 each stop length
    for (int w = 0; w < 4; w++) sendFrame(8'hA5, 2'(w), 1'b1, 1'(w), 2'(w), 1'b0);
    // R4: upper bits set above a 5-bit width
    sendFrame(8'hE0, 2'd0, 1'b1, 1'b0, 2'd1, 1'b0);
    sendFrame(8'hFF, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0);
    // R6: no parity, 1.5 stop
    sendFrame(8'h3C, 2'd3, 1'b0, 1'b1, 2'd1, 1'b0);
    // R9: back-to-back with txValid held
    sendFrame(8'h81, 2'd3, 1'b0, 1'b0, 2'd0, 1'b1);
    sendFrame(8'h7E, 2'd2, 1'b1, 1'b0, 2'd2, 1'b0);

    for (int i = 0; i < 50; i++)
      sendFrame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                2'($urandom), (i % 4 == 1));

    @(negedge clk); txValid = 1'b0;
    repeat (4) @(posedge clk); #1;
    check(txLine && txReady && !busy, "R2 idle after frames", {txLine, txReady, busy}, 3'b110);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule